// File: doc/BRIEF.md
# Device Lifecycle State Controller

This block keeps the current lifecycle stage of a device and decides which stage changes are allowed. There are four stages: an open stage for bring-up, an optional production stage in which an integrator adds its own assets, the deployed in-field stage, and a terminal failure-analysis stage. For every stage the block drives four permission lines: configuration, programming, debug and key import. It also drives a run enable that the rest of the chip uses for normal operation.

A request to change stage arrives on a valid/ready channel. The request carries a target stage, an authorization bit and nothing else. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` drops while an erase is in progress, so back-pressure only ever lasts for the length of an erase. A requester may hold or withdraw `req_valid` freely during that time, and nothing is taken. Moving forward along the chain needs no authorization. Leaving the in-field stage needs the authorization bit and the configured exit permission in the same cycle. It also starts an erase of firmware, keys and configuration through a request/acknowledge handshake, and the new stage takes effect only once the erase is acknowledged. A request that names a change not in the allowed set does nothing except set a sticky error flag.

Top module: `lc_ctrl`

## Requirements
- R1: After reset the stage is open (`lc_state`=0), all four permissions and `run_en` are 1, `bad_req`=0, `erase_req`=0 and `req_ready`=1.
- R2: Stage encoding is open=0, production=1, in-field=2, failure-analysis=3. The permissions {cfg,prog,dbg,key} are 1111 in open, 1001 in production, 0000 in in-field and 0010 in failure-analysis. `run_en` is 0 only in failure-analysis and during an erase.
- R3: With `OEM_STAGE_EN`=1, a taken request from open to production or from production to in-field is applied at the next clock edge, whatever the value of `req_auth`.
- R4: With `OEM_STAGE_EN`=0, production (1) is never a legal target, and open moves forward directly to in-field.
- R5: A request from in-field to open or to failure-analysis is legal only if `req_auth` and `exit_allow` are both 1 in the cycle it is taken. Otherwise it counts as undefined.
- R6: A legal exit from in-field raises `erase_req` at the next edge and holds it until `erase_ack` is seen. While it is held, `lc_state` stays 2, all permissions and `run_en` are 0, and `req_ready` is 0.
- R7: At the edge where `erase_req` and `erase_ack` are both 1, the requested target stage is committed and `erase_req` falls. `erase_ack` has no effect at any other time.
- R8: Failure-analysis is terminal. Every request made from it is undefined, and the stage never leaves 3 until reset.
- R9: An undefined request, including one naming the current stage, leaves the stage unchanged and sets `bad_req`, which stays 1 until reset.
- R10: A request presented while `req_ready` is 0 is not taken. It changes neither the stage nor `bad_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Transition request present |
| req_ready | output | 1 | Request can be taken (low during erase) |
| req_target | input | 2 | Requested stage code |
| req_auth | input | 1 | Authorization for an exit from in-field |
| exit_allow | input | 1 | Configured condition permitting in-field exit |
| erase_req | output | 1 | Full erase request, held until acknowledged |
| erase_ack | input | 1 | Erase completion acknowledge |
| perm_cfg | output | 1 | Configuration permitted |
| perm_prog | output | 1 | Programming permitted |
| perm_dbg | output | 1 | Debug permitted |
| perm_key | output | 1 | Key import permitted |
| run_en | output | 1 | Normal operation enabled |
| lc_state | output | 2 | Current stage code |
| bad_req | output | 1 | Sticky undefined-request flag |

## Verification
The bench builds one instance with `OEM_STAGE_EN`=1. That instance walks the full forward chain, both authorized exits with their erase handshakes, back-pressure during an erase, and the terminal failure-analysis stage. A second instance with `OEM_STAGE_EN`=0 is the only way to reach the direct open-to-in-field step, and the rejection of production as a target that R4 describes. Expected values come from the stage and permission table in the requirements and are compared by a scoreboard one edge after each stimulus.

// File: rtl/lc_pkg.sv
package lc_pkg;
  localparam int unsigned LC_W   = 2;
  localparam int unsigned PERM_W = 4;

  typedef enum logic [LC_W-1:0] {
    LC_OPEN  = 2'd0,
    LC_OEM   = 2'd1,
    LC_FIELD = 2'd2,
    LC_FA    = 2'd3
  } lc_state_e;

  typedef struct packed {
    logic cfg;
    logic prog;
    logic dbg;
    logic key;
  } lc_perm_t;
endpackage

// File: rtl/lc_trans_check.sv
module lc_trans_check
  import lc_pkg::*;
#(
  parameter bit OEM_STAGE_EN = 1'b1
) (
  input  lc_state_e cur_i,
  input  lc_state_e tgt_i,
  input  logic      auth_i,
  input  logic      exit_allow_i,
  output logic      legal_o,
  output logic      erase_o
);
  logic fwd;
  logic back;

  generate
    if (OEM_STAGE_EN) begin : g_oem
      always_comb
        fwd = ((cur_i == LC_OPEN) && (tgt_i == LC_OEM)) ||
              ((cur_i == LC_OEM)  && (tgt_i == LC_FIELD));
    end else begin : g_no_oem
      always_comb
        fwd = (cur_i == LC_OPEN) && (tgt_i == LC_FIELD);
    end
  endgenerate

  // leaving in-field: needs authorization plus the configured exit condition
  assign back = (cur_i == LC_FIELD) &&
                ((tgt_i == LC_OPEN) || (tgt_i == LC_FA)) &&
                auth_i && exit_allow_i;

  assign legal_o = fwd | back;
  assign erase_o = back;
endmodule

// File: rtl/lc_erase_seq.sv
module lc_erase_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic ack_i,
  output logic busy_o,
  output logic done_o
);
  logic busy_q;

  assign done_o = busy_q & ack_i;
  assign busy_o = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        busy_q <= 1'b0;
    else if (start_i)  busy_q <= 1'b1;
    else if (done_o)   busy_q <= 1'b0;
  end
endmodule

// File: rtl/lc_perm_map.sv
module lc_perm_map
  import lc_pkg::*;
(
  input  lc_state_e st_i,
  input  logic      hold_i,
  output lc_perm_t  perm_o,
  output logic      run_o
);
  always_comb begin
    perm_o = '0;
    run_o  = 1'b0;
    if (!hold_i) begin
      unique case (st_i)
        LC_OPEN:  begin perm_o = '{cfg:1'b1, prog:1'b1, dbg:1'b1, key:1'b1}; run_o = 1'b1; end
        LC_OEM:   begin perm_o = '{cfg:1'b1, prog:1'b0, dbg:1'b0, key:1'b1}; run_o = 1'b1; end
        LC_FIELD: begin perm_o = '0;                                          run_o = 1'b1; end
        LC_FA:    begin perm_o = '{cfg:1'b0, prog:1'b0, dbg:1'b1, key:1'b0}; run_o = 1'b0; end
        default:  begin perm_o = '0;                                          run_o = 1'b0; end
      endcase
    end
  end
endmodule

// File: rtl/lc_ctrl.sv
module lc_ctrl
  import lc_pkg::*;
#(
  parameter bit OEM_STAGE_EN = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [LC_W-1:0] req_target,
  input  logic            req_auth,
  input  logic            exit_allow,
  output logic            erase_req,
  input  logic            erase_ack,
  output logic            perm_cfg,
  output logic            perm_prog,
  output logic            perm_dbg,
  output logic            perm_key,
  output logic            run_en,
  output logic [LC_W-1:0] lc_state,
  output logic            bad_req
);
  lc_state_e st_q, tgt_q, tgt_in;
  logic      err_q;
  logic      legal, needs_erase, busy, done, take;
  lc_perm_t  perm;

  assign tgt_in    = lc_state_e'(req_target);
  assign req_ready = ~busy;
  assign take      = req_valid & ~busy;

  lc_trans_check #(.OEM_STAGE_EN(OEM_STAGE_EN)) u_check (
    .cur_i        (st_q),
    .tgt_i        (tgt_in),
    .auth_i       (req_auth),
    .exit_allow_i (exit_allow),
    .legal_o      (legal),
    .erase_o      (needs_erase)
  );

  lc_erase_seq u_erase (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (take & legal & needs_erase),
    .ack_i   (erase_ack),
    .busy_o  (busy),
    .done_o  (done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= LC_OPEN;
      tgt_q <= LC_OPEN;
      err_q <= 1'b0;
    end else begin
      if (done) st_q <= tgt_q;
      if (take) begin
        if (!legal)           err_q <= 1'b1;
        else if (needs_erase) tgt_q <= tgt_in;
        else                  st_q  <= tgt_in;
      end
    end
  end

  lc_perm_map u_perm (
    .st_i   (st_q),
    .hold_i (busy),
    .perm_o (perm),
    .run_o  (run_en)
  );

  assign perm_cfg  = perm.cfg;
  assign perm_prog = perm.prog;
  assign perm_dbg  = perm.dbg;
  assign perm_key  = perm.key;
  assign erase_req = busy;
  assign lc_state  = st_q;
  assign bad_req   = err_q;
endmodule

// File: rtl/lc_ctrl_chk.sv
module lc_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic       erase_req,
  input logic       erase_ack,
  input logic       perm_cfg,
  input logic       perm_prog,
  input logic       perm_dbg,
  input logic       perm_key,
  input logic       run_en,
  input logic [1:0] lc_state,
  input logic       bad_req
);
  a_r6_erase_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_req && !erase_ack) |=> erase_req);

  a_r6_perm_off: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |-> ({perm_cfg, perm_prog, perm_dbg, perm_key} == 4'b0000 && !run_en
                   && lc_state == 2'd2));

  a_r7_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_req && erase_ack) |=> (!erase_req && lc_state != 2'd2));

  a_r5_field_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (lc_state == 2'd2 && !erase_req) |=> (lc_state == 2'd2));

  a_r8_fa_terminal: assert property (@(posedge clk) disable iff (!rst_n)
    (lc_state == 2'd3) |=> (lc_state == 2'd3 && !run_en));

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    bad_req |=> bad_req);

  a_r10_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |-> !req_ready);

  a_r2_field_perm: assert property (@(posedge clk) disable iff (!rst_n)
    (lc_state == 2'd2) |-> ({perm_cfg, perm_prog, perm_dbg, perm_key} == 4'b0000));
endmodule

bind lc_ctrl lc_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .erase_req(erase_req),
  .erase_ack(erase_ack), .perm_cfg(perm_cfg), .perm_prog(perm_prog),
  .perm_dbg(perm_dbg), .perm_key(perm_key), .run_en(run_en),
  .lc_state(lc_state), .bad_req(bad_req)
);

// File: tb/lc_ctrl_tb_top.sv
`timescale 1ns/1ps
module lc_ctrl_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  // instance with production stage
  logic       rst_n, v, a, x, k;
  logic [1:0] t;
  logic       rdy, ereq, pc, pp, pd, pk, run, err;
  logic [1:0] st;

  lc_ctrl #(.OEM_STAGE_EN(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(v), .req_ready(rdy), .req_target(t),
    .req_auth(a), .exit_allow(x), .erase_req(ereq), .erase_ack(k),
    .perm_cfg(pc), .perm_prog(pp), .perm_dbg(pd), .perm_key(pk),
    .run_en(run), .lc_state(st), .bad_req(err)
  );

  // instance without production stage
  logic       bv;
  logic [1:0] bt;
  logic       brdy, bereq, bpc, bpp, bpd, bpk, brun, berr;
  logic [1:0] bst;

  lc_ctrl #(.OEM_STAGE_EN(1'b0)) dut_b (
    .clk(clk), .rst_n(rst_n), .req_valid(bv), .req_ready(brdy), .req_target(bt),
    .req_auth(1'b0), .exit_allow(1'b0), .erase_req(bereq), .erase_ack(1'b0),
    .perm_cfg(bpc), .perm_prog(bpp), .perm_dbg(bpd), .perm_key(bpk),
    .run_en(brun), .lc_state(bst), .bad_req(berr)
  );

  // expected vector: {state[1:0], cfg, prog, dbg, key, run, err, erase_req, ready}
  logic [9:0] exp_q[$];
  string      tag_q[$];

  function automatic logic [9:0] ex(input logic [1:0] s, input logic [3:0] p,
                                    input logic r, input logic e,
                                    input logic q, input logic y);
    return {s, p, r, e, q, y};
  endfunction

  task automatic step(input logic vv, input logic [1:0] tt, input logic aa,
                      input logic xx, input logic kk, input logic [9:0] e,
                      input string tag);
    @(negedge clk);
    v = vv; t = tt; a = aa; x = xx; k = kk;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; v = 0; t = 0; a = 0; x = 0; k = 0; bv = 0; bt = 0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // monitor: compare one edge after each stimulus
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [9:0] e, got;
        string tg;
        e  = exp_q.pop_front();
        tg = tag_q.pop_front();
        got = {st, pc, pp, pd, pk, run, err, ereq, rdy};
        total++;
        if (got !== e) begin
          bad++;
          $display("FAIL %s actual=%b expected=%b", tg, got, e);
        end
      end
    end
  end

  task automatic chk_b(input logic [1:0] s, input logic e, input string tag);
    total++;
    if (bst !== s || berr !== e) begin
      bad++;
      $display("FAIL %s actual st=%0d err=%b expected st=%0d err=%b", tag, bst, berr, s, e);
    end
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; v = 0; t = 0; a = 0; x = 0; k = 0; bv = 0; bt = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    step(0, 2'd0, 0, 0, 0, ex(2'd0, 4'b1111, 1, 0, 0, 1), "R1 reset state");
    step(1, 2'd1, 0, 0, 0, ex(2'd1, 4'b1001, 1, 0, 0, 1), "R3 open->production R2");
    step(1, 2'd2, 0, 0, 0, ex(2'd2, 4'b0000, 1, 0, 0, 1), "R3 production->in-field R2");
    step(1, 2'd0, 1, 1, 0, ex(2'd2, 4'b0000, 0, 0, 1, 0), "R6 exit starts erase");
    step(0, 2'd0, 0, 0, 0, ex(2'd2, 4'b0000, 0, 0, 1, 0), "R6 erase held");
    step(1, 2'd1, 0, 0, 0, ex(2'd2, 4'b0000, 0, 0, 1, 0), "R10 request while busy");
    step(0, 2'd0, 0, 0, 1, ex(2'd0, 4'b1111, 1, 0, 0, 1), "R7 commit to open");
    step(0, 2'd0, 0, 0, 1, ex(2'd0, 4'b1111, 1, 0, 0, 1), "R7 stray ack ignored");
    step(1, 2'd1, 1, 0, 0, ex(2'd1, 4'b1001, 1, 0, 0, 1), "R3 forward with auth set");
    step(1, 2'd2, 0, 0, 0, ex(2'd2, 4'b0000, 1, 0, 0, 1), "R3 into in-field again");
    step(1, 2'd3, 1, 1, 0, ex(2'd2, 4'b0000, 0, 0, 1, 0), "R6 exit to failure-analysis");
    step(0, 2'd0, 0, 0, 1, ex(2'd3, 4'b0010, 0, 0, 0, 1), "R7 commit to failure-analysis R2");
    step(1, 2'd0, 1, 1, 0, ex(2'd3, 4'b0010, 0, 1, 0, 1), "R8 request from failure-analysis R9");
    step(0, 2'd0, 0, 0, 1, ex(2'd3, 4'b0010, 0, 1, 0, 1), "R8 stays terminal");
    do_reset();

    step(0, 2'd0, 0, 0, 0, ex(2'd0, 4'b1111, 1, 0, 0, 1), "R1 reset clears flag");
    step(1, 2'd2, 0, 0, 0, ex(2'd0, 4'b1111, 1, 1, 0, 1), "R9 skip production");
    do_reset();

    step(1, 2'd0, 0, 0, 0, ex(2'd0, 4'b1111, 1, 1, 0, 1), "R9 same-stage request");
    do_reset();

    step(1, 2'd1, 0, 0, 0, ex(2'd1, 4'b1001, 1, 0, 0, 1), "R3 to production");
    step(1, 2'd2, 0, 0, 0, ex(2'd2, 4'b0000, 1, 0, 0, 1), "R3 to in-field");
    step(1, 2'd0, 0, 1, 0, ex(2'd2, 4'b0000, 1, 1, 0, 1), "R5 exit without auth");
    do_reset();

    step(1, 2'd1, 0, 0, 0, ex(2'd1, 4'b1001, 1, 0, 0, 1), "R3 to production");
    step(1, 2'd2, 0, 0, 0, ex(2'd2, 4'b0000, 1, 0, 0, 1), "R3 to in-field");
    step(1, 2'd3, 1, 0, 0, ex(2'd2, 4'b0000, 1, 1, 0, 1), "R5 exit without exit_allow");
    step(0, 2'd0, 0, 0, 0, ex(2'd2, 4'b0000, 1, 1, 0, 1), "R9 flag sticky");
    do_reset();

    // instance without production stage (R4)
    @(negedge clk); bv = 1; bt = 2'd1;
    @(posedge clk); #1; chk_b(2'd0, 1'b1, "R4 production target rejected");
    do_reset();
    @(negedge clk); bv = 1; bt = 2'd2;
    @(posedge clk); #1; chk_b(2'd2, 1'b0, "R4 open->in-field direct");
    @(negedge clk); bv = 0;
    @(posedge clk); #1; chk_b(2'd2, 1'b0, "R4 in-field held");

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule